// File: doc/BRIEF.md
# Streaming Randomness Health Monitor

This block watches the serial output of a random bit source and grades a sample of exactly 20000 bits against four statistical checks: the balance of ones and zeros, the spread of 4-bit patterns, the count of runs of each length, and the absence of any very long run. Every accepted bit updates its counters as it arrives and the sample is never stored, so almost no work remains once the last bit has been taken. Each check gets its own pass flag, and a combined flag and a one-cycle done pulse follow a few cycles after the final bit.

A new sample starts with a one-cycle clear. The control is a five-state machine. COLLECT accepts bits while a strobe is high and counts them; the transition COLLECT to CLOSE fires on the 20000th accepted bit. CLOSE folds the still-open run into the run tallies and always moves on to SQUARE. SQUARE sums the squares of the sixteen pattern counters, several per cycle with multipliers and no divider, and moves to JUDGE after its last step. JUDGE makes the pattern verdict, raises done and moves to HOLD. HOLD keeps every verdict and ignores all input bits. Clear sends any state back to COLLECT. Reset also leaves the machine in COLLECT.

All flags use 1 for pass. The pattern statistic is compared as an exact integer: sixteen times the sum of squared pattern counts is compared with two fixed constants. No real-valued scale factor is needed.

Top module: `rng_health_monitor`

## Requirements
- R1: Only a bit with `bit_valid_i` high in COLLECT, with `clear_i` low, is accepted. The sample closes on the 20000th accepted bit, and no verdict or done appears before that.
- R2: The frequency flag is 1 exactly when the number of ones among the 20000 bits is between 9726 and 10274 inclusive.
- R3: Each group of four consecutive accepted bits is one pattern, giving 5000 patterns with counts f0..f15. The pattern flag is 1 exactly when 25010800 < 16·Σfi² < 25230850.
- R4: Maximal runs of equal bits are tallied separately for zeros and for ones, in the length classes 1, 2, 3, 4, 5 and 6-or-more. The runs flag is 1 only when all twelve tallies lie in their closed bands: 2315..2685, 1114..1386, 527..723, 240..384, 103..209 and 103..209.
- R5: The long-run flag is 0 when any run, including the final one, reaches 26 bits or more. Otherwise it is 1.
- R6: The run still open after the 20000th bit is closed and counted in the runs tallies.
- R7: Counting the edge that accepts the last bit as edge 0, the frequency, runs and long-run flags are valid after edge 2. The pattern flag, the overall flag and `done_o` become valid after edge 6. `done_o` is high for exactly one cycle.
- R8: The overall flag equals the AND of the four test flags.
- R9: When `clear_i` is high, the next edge zeroes every counter and flag and returns to COLLECT. A bit offered in that same cycle is discarded.
- R10: Bits offered from the last accepted bit until the next clear have no effect. The flags hold their values and done stays low.
- R11: After reset, every flag and `done_o` are 0 and the block is in COLLECT.
- R12: A source stuck at 0 or stuck at 1 gives an overall flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new sample; wipes counters and flags |
| bit_valid_i | input | 1 | Strobe: `bit_i` holds a new source bit |
| bit_i | input | 1 | Source bit |
| done_o | output | 1 | One-cycle pulse when all verdicts are final |
| freq_pass_o | output | 1 | Ones-count test passed |
| poker_pass_o | output | 1 | 4-bit pattern test passed |
| runs_pass_o | output | 1 | Run-length tally test passed |
| lrun_pass_o | output | 1 | No run of 26 or more |
| all_pass_o | output | 1 | All four tests passed |

## Verification
Two events can fall in the same cycle: a clear and a valid source bit. The bench provokes this by raising clear together with a strobed 1 at the start of one sample. If that bit were wrongly counted, the sample would close one cycle early, and the exact-cycle checks on the flags and done would catch it. A second overlap is a new bit arriving while the machine is in CLOSE or SQUARE. The bench keeps strobing random bits through the whole evaluation window and through HOLD, and judges that the verdicts still match the bench's own model of the 20000 accepted bits.

// File: rtl/rhm_pkg.sv
package rhm_pkg;

    localparam int unsigned SAMPLE_BITS = 20000;
    localparam int unsigned CNT_W       = $clog2(SAMPLE_BITS + 1);
    localparam int unsigned NIBBLES     = SAMPLE_BITS / 4;
    localparam int unsigned NIB_W       = $clog2(NIBBLES + 1);
    localparam int unsigned PATTERNS    = 16;
    localparam int unsigned ACC_W       = 2 * NIB_W + 4;
    localparam int unsigned RUN_CLASSES = 6;

    // ones-count band, inclusive
    localparam int unsigned FREQ_LO = 9726;
    localparam int unsigned FREQ_HI = 10274;

    // exclusive bounds on 16 * sum of squares (offset by NIBBLES^2)
    localparam int unsigned POKER_LO = NIBBLES * NIBBLES + 10800;
    localparam int unsigned POKER_HI = NIBBLES * NIBBLES + 230850;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_CLOSE,
        ST_SQUARE,
        ST_JUDGE,
        ST_HOLD
    } rhm_state_e;

    function automatic int unsigned run_band_lo(input int unsigned cls);
        unique case (cls)
            0:       return 2315;
            1:       return 1114;
            2:       return 527;
            3:       return 240;
            default: return 103;
        endcase
    endfunction

    function automatic int unsigned run_band_hi(input int unsigned cls);
        unique case (cls)
            0:       return 2685;
            1:       return 1386;
            2:       return 723;
            3:       return 384;
            default: return 209;
        endcase
    endfunction

endpackage

// File: rtl/rhm_ctrl.sv
module rhm_ctrl
    import rhm_pkg::*;
#(
    parameter  int unsigned STEPS  = 4,
    localparam int unsigned STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              bit_valid_i,
    output logic              accept_o,
    output logic              close_o,
    output logic              sq_en_o,
    output logic [STEP_W-1:0] sq_step_o,
    output logic              latch_basic_o,
    output logic              judge_o,
    output logic              done_o
);

    rhm_state_e        state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [STEP_W-1:0] step;
    logic              last_bit;
    logic              done_q;

    assign last_bit = accept_o && (bit_cnt == CNT_W'(SAMPLE_BITS - 1));

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_COLLECT;
            bit_cnt <= '0;
            step    <= '0;
            done_q  <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= !clear_i && (state == ST_JUDGE);
            if (clear_i)
                bit_cnt <= '0;
            else if (accept_o)
                bit_cnt <= bit_cnt + 1'b1;
            if (clear_i || state != ST_SQUARE)
                step <= '0;
            else
                step <= step + 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLLECT: if (last_bit) nxt = ST_CLOSE;
            ST_CLOSE:   nxt = ST_SQUARE;
            ST_SQUARE:  if (step == STEP_W'(STEPS - 1)) nxt = ST_JUDGE;
            ST_JUDGE:   nxt = ST_HOLD;
            ST_HOLD:    nxt = ST_HOLD;
            default:    nxt = ST_COLLECT;
        endcase
        if (clear_i)
            nxt = ST_COLLECT;
    end

    // outputs
    always_comb begin
        accept_o      = 1'b0;
        close_o       = 1'b0;
        sq_en_o       = 1'b0;
        latch_basic_o = 1'b0;
        judge_o       = 1'b0;
        unique case (state)
            ST_COLLECT: accept_o = bit_valid_i && !clear_i;
            ST_CLOSE:   close_o  = !clear_i;
            ST_SQUARE: begin
                sq_en_o       = !clear_i;
                latch_basic_o = !clear_i && (step == '0);
            end
            ST_JUDGE:   judge_o  = !clear_i;
            default:    ;
        endcase
        sq_step_o = step;
        done_o    = done_q;
    end

endmodule

// File: rtl/rhm_run_tracker.sv
module rhm_run_tracker
    import rhm_pkg::*;
#(
    parameter  int unsigned LONG_RUN = 26,
    localparam int unsigned RUN_W    = $clog2(LONG_RUN + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear_i,
    input  logic                                  accept_i,
    input  logic                                  bit_i,
    input  logic                                  close_i,
    output logic [2*RUN_CLASSES-1:0][CNT_W-1:0]   tally_o,
    output logic                                  long_hit_o
);

    logic             have_run;
    logic             cur_bit;
    logic [RUN_W-1:0] run_len;
    logic [2:0]       run_cls;
    logic             extend;
    logic             end_run;

    assign extend  = accept_i && have_run && (bit_i == cur_bit);
    assign end_run = have_run && ((accept_i && (bit_i != cur_bit)) || close_i);
    assign run_cls = (run_len >= RUN_W'(RUN_CLASSES)) ? 3'(RUN_CLASSES - 1)
                                                     : 3'(run_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_run   <= 1'b0;
            cur_bit    <= 1'b0;
            run_len    <= '0;
            long_hit_o <= 1'b0;
        end else if (clear_i) begin
            have_run   <= 1'b0;
            cur_bit    <= 1'b0;
            run_len    <= '0;
            long_hit_o <= 1'b0;
        end else if (close_i) begin
            have_run <= 1'b0;
        end else if (accept_i) begin
            if (extend) begin
                if (run_len != RUN_W'(LONG_RUN))
                    run_len <= run_len + 1'b1;
                if (run_len >= RUN_W'(LONG_RUN - 1))
                    long_hit_o <= 1'b1;
            end else begin
                have_run <= 1'b1;
                cur_bit  <= bit_i;
                run_len  <= RUN_W'(1);
            end
        end
    end

    for (genvar v = 0; v < 2; v++) begin : g_val
        for (genvar c = 0; c < RUN_CLASSES; c++) begin : g_cls
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    tally_o[v*RUN_CLASSES+c] <= '0;
                else if (clear_i)
                    tally_o[v*RUN_CLASSES+c] <= '0;
                else if (end_run && (cur_bit == 1'(v)) && (run_cls == 3'(c)))
                    tally_o[v*RUN_CLASSES+c] <= tally_o[v*RUN_CLASSES+c] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rhm_pattern_counter.sv
module rhm_pattern_counter
    import rhm_pkg::*;
#(
    parameter  int unsigned PER_STEP = 4,
    localparam int unsigned STEPS    = PATTERNS / PER_STEP,
    localparam int unsigned STEP_W   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              accept_i,
    input  logic              bit_i,
    input  logic              sq_en_i,
    input  logic [STEP_W-1:0] sq_step_i,
    output logic [ACC_W-1:0]  sumsq_o
);

    logic [2:0]       shift;
    logic [1:0]       phase;
    logic [3:0]       pattern;
    logic [NIB_W-1:0] freq_cnt [PATTERNS];
    logic [ACC_W-1:0] partial;

    assign pattern = {shift, bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift <= '0;
            phase <= '0;
        end else if (clear_i) begin
            shift <= '0;
            phase <= '0;
        end else if (accept_i) begin
            shift <= pattern[2:0];
            phase <= phase + 1'b1;
        end
    end

    for (genvar n = 0; n < PATTERNS; n++) begin : g_pat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                freq_cnt[n] <= '0;
            else if (clear_i)
                freq_cnt[n] <= '0;
            else if (accept_i && phase == 2'd3 && pattern == 4'(n))
                freq_cnt[n] <= freq_cnt[n] + 1'b1;
        end
    end

    // PER_STEP parallel squarers, one slice of the counters per step
    always_comb begin
        partial = '0;
        for (int k = 0; k < PER_STEP; k++) begin
            partial = partial
                + ACC_W'(freq_cnt[4'(int'(sq_step_i) * PER_STEP + k)])
                * ACC_W'(freq_cnt[4'(int'(sq_step_i) * PER_STEP + k)]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sumsq_o <= '0;
        else if (clear_i)
            sumsq_o <= '0;
        else if (sq_en_i)
            sumsq_o <= sumsq_o + partial;
    end

endmodule

// File: rtl/rng_health_monitor.sv
module rng_health_monitor
    import rhm_pkg::*;
#(
    parameter  int unsigned LONG_RUN = 26,
    parameter  int unsigned PER_STEP = 4,
    localparam int unsigned STEPS    = PATTERNS / PER_STEP,
    localparam int unsigned STEP_W   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic done_o,
    output logic freq_pass_o,
    output logic poker_pass_o,
    output logic runs_pass_o,
    output logic lrun_pass_o,
    output logic all_pass_o
);

    logic                                accept;
    logic                                close_run;
    logic                                sq_en;
    logic [STEP_W-1:0]                   sq_step;
    logic                                latch_basic;
    logic                                judge;
    logic [2*RUN_CLASSES-1:0][CNT_W-1:0] tally;
    logic                                long_hit;
    logic [ACC_W-1:0]                    sumsq;
    logic [CNT_W-1:0]                    ones;
    logic                                runs_ok;
    logic                                freq_ok;
    logic                                poker_ok;
    logic [ACC_W+3:0]                    poker_scaled;

    rhm_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .bit_valid_i   (bit_valid_i),
        .accept_o      (accept),
        .close_o       (close_run),
        .sq_en_o       (sq_en),
        .sq_step_o     (sq_step),
        .latch_basic_o (latch_basic),
        .judge_o       (judge),
        .done_o        (done_o)
    );

    rhm_run_tracker #(.LONG_RUN(LONG_RUN)) u_runs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .accept_i   (accept),
        .bit_i      (bit_i),
        .close_i    (close_run),
        .tally_o    (tally),
        .long_hit_o (long_hit)
    );

    rhm_pattern_counter #(.PER_STEP(PER_STEP)) u_pat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .accept_i  (accept),
        .bit_i     (bit_i),
        .sq_en_i   (sq_en),
        .sq_step_i (sq_step),
        .sumsq_o   (sumsq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ones <= '0;
        else if (clear_i)
            ones <= '0;
        else if (accept && bit_i)
            ones <= ones + 1'b1;
    end

    assign freq_ok = (ones >= CNT_W'(FREQ_LO)) && (ones <= CNT_W'(FREQ_HI));

    always_comb begin
        runs_ok = 1'b1;
        for (int i = 0; i < 2 * RUN_CLASSES; i++) begin
            if (int'(tally[i]) < int'(run_band_lo(i % RUN_CLASSES)) ||
                int'(tally[i]) > int'(run_band_hi(i % RUN_CLASSES)))
                runs_ok = 1'b0;
        end
    end

    assign poker_scaled = {sumsq, 4'b0000};
    assign poker_ok     = (poker_scaled > (ACC_W+4)'(POKER_LO)) &&
                          (poker_scaled < (ACC_W+4)'(POKER_HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_pass_o  <= 1'b0;
            runs_pass_o  <= 1'b0;
            lrun_pass_o  <= 1'b0;
            poker_pass_o <= 1'b0;
            all_pass_o   <= 1'b0;
        end else if (clear_i) begin
            freq_pass_o  <= 1'b0;
            runs_pass_o  <= 1'b0;
            lrun_pass_o  <= 1'b0;
            poker_pass_o <= 1'b0;
            all_pass_o   <= 1'b0;
        end else begin
            if (latch_basic) begin
                freq_pass_o <= freq_ok;
                runs_pass_o <= runs_ok;
                lrun_pass_o <= !long_hit;
            end
            if (judge) begin
                poker_pass_o <= poker_ok;
                all_pass_o   <= poker_ok && freq_pass_o && runs_pass_o && lrun_pass_o;
            end
        end
    end

endmodule

// File: rtl/rhm_checker.sv
module rhm_checker (
    input logic clk,
    input logic rst_n,
    input logic clear_i,
    input logic done_o,
    input logic freq_pass_o,
    input logic poker_pass_o,
    input logic runs_pass_o,
    input logic lrun_pass_o,
    input logic all_pass_o
);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_poker_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poker_pass_o) |-> done_o);

    assert_all_is_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
        all_pass_o |-> (freq_pass_o && poker_pass_o && runs_pass_o && lrun_pass_o));

    assert_clear_wipes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !(done_o || freq_pass_o || poker_pass_o || runs_pass_o ||
                      lrun_pass_o || all_pass_o));

    assert_poker_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(clear_i)) |-> $stable(poker_pass_o));

    assert_all_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(clear_i)) |-> $stable(all_pass_o));

endmodule

bind rng_health_monitor rhm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .done_o       (done_o),
    .freq_pass_o  (freq_pass_o),
    .poker_pass_o (poker_pass_o),
    .runs_pass_o  (runs_pass_o),
    .lrun_pass_o  (lrun_pass_o),
    .all_pass_o   (all_pass_o)
);

// File: tb/sim_rng_health_monitor.sv
module sim_rng_health_monitor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0;
    logic bit_valid_i = 1'b0;
    logic bit_i = 1'b0;
    logic done_o, freq_pass_o, poker_pass_o, runs_pass_o, lrun_pass_o, all_pass_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model of the accepted sample
    int ones, ph, nibv, have, cur, len, longest;
    int nib [16];
    int tal [2][6];
    bit e_freq, e_poker, e_runs, e_lrun, e_all;

    always #10 clk = ~clk;

    rng_health_monitor u0 (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .bit_valid_i(bit_valid_i),
        .bit_i(bit_i), .done_o(done_o), .freq_pass_o(freq_pass_o),
        .poker_pass_o(poker_pass_o), .runs_pass_o(runs_pass_o),
        .lrun_pass_o(lrun_pass_o), .all_pass_o(all_pass_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<190000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        ones = 0; ph = 0; nibv = 0; have = 0; cur = 0; len = 0; longest = 0;
        for (int i = 0; i < 16; i++) nib[i] = 0;
        for (int v = 0; v < 2; v++) for (int c = 0; c < 6; c++) tal[v][c] = 0;
    endfunction

    function automatic void mdl_take(input int b);
        ones += b;
        nibv = ((nibv << 1) | b) & 15;
        ph++;
        if (ph == 4) begin nib[nibv]++; ph = 0; end
        if (have == 0) begin have = 1; cur = b; len = 1; end
        else if (b == cur) len++;
        else begin tal[cur][(len >= 6) ? 5 : len - 1]++; cur = b; len = 1; end
        if (len > longest) longest = len;
    endfunction

    function automatic void mdl_finish();
        int lo [6];
        int hi [6];
        longint sq;
        longint s;
        lo = '{2315, 1114, 527, 240, 103, 103};
        hi = '{2685, 1386, 723, 384, 209, 209};
        if (have != 0) tal[cur][(len >= 6) ? 5 : len - 1]++;   // R6 open run closed
        e_freq = (ones >= 9726) && (ones <= 10274);
        sq = 0;
        for (int i = 0; i < 16; i++) sq += longint'(nib[i]) * nib[i];
        s = 16 * sq - 25000000;
        e_poker = (s > 10800) && (s < 230850);
        e_runs = 1'b1;
        for (int v = 0; v < 2; v++)
            for (int c = 0; c < 6; c++)
                if (tal[v][c] < lo[c] || tal[v][c] > hi[c]) e_runs = 1'b0;
        e_lrun = (longest < 26);
        e_all = e_freq && e_poker && e_runs && e_lrun;
    endfunction

    function automatic int gen_bit(input int kind, input int i);
        case (kind)
            1: return 0;
            2: return 1;
            3: return (i >= 19973) ? 1 : ((i == 19972) ? 0 : int'($urandom % 2));
            4: return i % 2;
            default: return int'($urandom % 2);
        endcase
    endfunction

    task automatic do_clear(input bit collide);
        @(negedge clk);
        clear_i = 1'b1;
        bit_valid_i = collide;
        bit_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        bit_valid_i = 1'b0;
        chk("R9 clear zeroes flags", freq_pass_o | poker_pass_o | runs_pass_o |
            lrun_pass_o | all_pass_o | done_o, 1'b0);
        mdl_reset();
    endtask

    task automatic drive_bit(input int b, input bit gaps);
        if (gaps && ($urandom % 8 == 0)) begin
            bit_valid_i = 1'b0;
            bit_i = 1'($urandom % 2);
            @(negedge clk);
        end
        bit_valid_i = 1'b1;
        bit_i = 1'(b);
        @(posedge clk);
        mdl_take(b);
        @(negedge clk);
        bit_valid_i = 1'b0;
    endtask

    task automatic noise();
        bit_valid_i = 1'($urandom % 2);
        bit_i = 1'($urandom % 2);
    endtask

    task automatic run_sample(input int kind, input bit gaps, input bit collide,
                              input string tag);
        bit hold_done;
        do_clear(collide);
        for (int i = 0; i < 19999; i++) drive_bit(gen_bit(kind, i), gaps);
        // last bit: edge 0
        bit_valid_i = 1'b1;
        bit_i = 1'(gen_bit(kind, 19999));
        chk({"R1 no done before last bit ", tag}, done_o, 1'b0);
        @(posedge clk);
        mdl_take(int'(bit_i));
        mdl_finish();
        @(negedge clk);
        noise();  // R10: bits during evaluation ignored
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) chk({"R7 flags not yet at edge1 ", tag}, freq_pass_o | runs_pass_o, 1'b0);
            if (k == 2) begin
                chk({"R2 freq ", tag}, freq_pass_o, e_freq);
                chk({"R4 R6 runs ", tag}, runs_pass_o, e_runs);
                chk({"R5 longest ", tag}, lrun_pass_o, e_lrun);
                chk({"R7 done low at edge2 ", tag}, done_o, 1'b0);
            end
            if (k == 5) chk({"R7 done low at edge5 ", tag}, done_o, 1'b0);
            if (k == 6) begin
                chk({"R7 done at edge6 ", tag}, done_o, 1'b1);
                chk({"R3 poker ", tag}, poker_pass_o, e_poker);
                chk({"R8 overall ", tag}, all_pass_o, e_all);
            end
            if (k == 7) chk({"R7 done one cycle ", tag}, done_o, 1'b0);
            noise();
        end
        hold_done = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            hold_done |= done_o;
            noise();
        end
        chk({"R10 done stays low in hold ", tag}, hold_done, 1'b0);
        chk({"R10 freq held ", tag}, freq_pass_o, e_freq);
        chk({"R10 poker held ", tag}, poker_pass_o, e_poker);
        chk({"R10 overall held ", tag}, all_pass_o, e_all);
        bit_valid_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        mdl_reset();
        repeat (3) @(negedge clk);
        chk("R11 reset done", done_o, 1'b0);
        chk("R11 reset flags", freq_pass_o | poker_pass_o | runs_pass_o |
            lrun_pass_o | all_pass_o, 1'b0);
        rst_n = 1'b1;

        run_sample(0, 1'b0, 1'b0, "random");
        run_sample(1, 1'b0, 1'b0, "stuck0");
        chk("R12 stuck at 0 fails", all_pass_o, 1'b0);
        // R9: clear collides with a strobed bit
        run_sample(2, 1'b0, 1'b1, "stuck1 collide");
        chk("R12 stuck at 1 fails", all_pass_o, 1'b0);
        // R9: abandon a partial sample midway
        do_clear(1'b0);
        for (int i = 0; i < 300; i++) drive_bit(1, 1'b0);
        run_sample(0, 1'b1, 1'b0, "random gaps");
        run_sample(3, 1'b0, 1'b0, "long tail");
        chk("R5 final 27-run fails", lrun_pass_o, 1'b0);
        run_sample(4, 1'b0, 1'b0, "alternating");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule